// File: doc/BRIEF.md
# Per-Block Write Protection Controller

This controller keeps one write-protect flag for every erase block of a small word-wide flash array. A block is selected by the upper address bits of the array, which the host supplies as a block index. A protect request marks one block as protected after a fixed, parameterised delay. An unprotect request clears every flag together after a second, longer delay. Unprotect is only accepted once every block is already protected. A request that arrives too early is refused with a one-cycle error pulse and leaves the flags as they were.

Protection requests come from two sources that act on the same flags: a dedicated sideband pair, and a pair driven by the command-sequence decoder. While a timed operation runs, `busy` is high and any new request from either source is dropped.

Separately from the timed operations, the controller answers verify reads with a status byte. It also judges each program or erase request on the spot. A request aimed at a protected block is inhibited, so the array is never touched. A request aimed at an unprotected block is granted.

Top module: `blkprot_ctrl`

## Requirements
- R1: After reset all flags are clear (every verify read gives 0x00), `busy` is low and `unprot_err` is low.
- R2: An accepted protect request raises `busy` on the next clock edge and keeps it high for exactly PROT_CYC cycles. When it drops, the flag of the requested block is set and no other flag changes.
- R3: An unprotect request accepted while all blocks are protected keeps `busy` high for exactly UNPROT_CYC cycles. When it drops, every flag is clear.
- R4: An unprotect request made while any flag is clear pulses `unprot_err` high for one cycle. It leaves every flag unchanged and does not raise `busy`.
- R5: A verify request produces `vfy_valid` high one cycle later. `vfy_data` is then 0x01 if the addressed block is protected and 0x00 if it is not.
- R6: A program/erase request aimed at a protected block gives `pe_inhibit`=1 and `pe_grant`=0 in the same cycle, combinationally.
- R7: A program/erase request aimed at an unprotected block gives `pe_grant`=1 and `pe_inhibit`=0 in the same cycle.
- R8: Any protect or unprotect request made while `busy` is high is ignored and changes no flag.
- R9: The command path sets flags exactly as the sideband path does. If both ask to protect in the same cycle, only the sideband block is protected.
- R10: When a protect and an unprotect request arrive in the same cycle, the protect is taken and no error pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sb_prot | input | 1 | Sideband protect request |
| sb_unprot | input | 1 | Sideband unprotect-all request |
| sb_blk | input | BLK_BITS | Sideband block index (upper address bits) |
| cmd_prot | input | 1 | Command-path protect request |
| cmd_unprot | input | 1 | Command-path unprotect-all request |
| cmd_blk | input | BLK_BITS | Command-path block index |
| vfy_req | input | 1 | Verify read request |
| vfy_blk | input | BLK_BITS | Block index to verify |
| pe_req | input | 1 | Program/erase request to be judged |
| pe_blk | input | BLK_BITS | Target block of the program/erase request |
| vfy_data | output | 8 | Verify byte: 0x01 protected, 0x00 unprotected |
| vfy_valid | output | 1 | Verify byte is valid |
| busy | output | 1 | Timed protect/unprotect operation in progress |
| pe_inhibit | output | 1 | Program/erase request vetoed |
| pe_grant | output | 1 | Program/erase request allowed |
| unprot_err | output | 1 | One-cycle pulse for a refused unprotect |

## Verification
Protect requests are issued on both paths. Each is followed by verify reads of the target block and of a neighbour, which separates a correct single-flag update from a wrong index or a spill into other flags. Unprotect is tried twice: once with the flags partly set, where it must produce only the error pulse, and once with all flags set, where the exact busy length and the full clear are checked. Same-cycle collisions between the two paths, and between protect and unprotect, expose the priority order. Requests issued mid-operation show that a running timer locks out new work.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROT   = 2'd1,
    OP_UNPROT = 2'd2
  } op_e;

  // verify byte for one flag
  function automatic logic [7:0] vfy_byte(input logic flag);
    return flag ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/blkprot_req_arb.sv
module blkprot_req_arb #(
  parameter int BLK_BITS = 4
) (
  input  logic                idle,
  input  logic                sb_prot,
  input  logic                sb_unprot,
  input  logic [BLK_BITS-1:0] sb_blk,
  input  logic                cmd_prot,
  input  logic                cmd_unprot,
  input  logic [BLK_BITS-1:0] cmd_blk,
  output logic                prot_go,
  output logic                unprot_go,
  output logic [BLK_BITS-1:0] go_blk
);
  // priority: sideband protect, command protect, then unprotect
  always_comb begin
    prot_go   = 1'b0;
    unprot_go = 1'b0;
    go_blk    = sb_blk;
    if (idle) begin
      if (sb_prot) begin
        prot_go = 1'b1;
      end else if (cmd_prot) begin
        prot_go = 1'b1;
        go_blk  = cmd_blk;
      end else if (sb_unprot || cmd_unprot) begin
        unprot_go = 1'b1;
      end
    end
  end
endmodule

// File: rtl/blkprot_timer.sv
module blkprot_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign running = run_q;
  assign expire  = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= load;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> running);
endmodule

// File: rtl/blkprot_flags.sv
module blkprot_flags
  import blkprot_pkg::*;
#(
  parameter int BLK_BITS = 4,
  localparam int NBLK = 1 << BLK_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [BLK_BITS-1:0] set_blk,
  input  logic                clr_en,
  input  logic                vfy_req,
  input  logic [BLK_BITS-1:0] vfy_blk,
  input  logic                pe_req,
  input  logic [BLK_BITS-1:0] pe_blk,
  output logic [NBLK-1:0]     flags,
  output logic [7:0]          vfy_data,
  output logic                vfy_valid,
  output logic                pe_inhibit,
  output logic                pe_grant
);
  logic [NBLK-1:0] flags_q;
  assign flags = flags_q;

  for (genvar b = 0; b < NBLK; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      flags_q[b] <= 1'b0;
      else if (clr_en)                                 flags_q[b] <= 1'b0;
      else if (set_en && (set_blk == BLK_BITS'(b)))    flags_q[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vfy_valid <= 1'b0;
      vfy_data  <= 8'h00;
    end else begin
      vfy_valid <= vfy_req;
      if (vfy_req) vfy_data <= vfy_byte(flags_q[vfy_blk]);
    end
  end

  assign pe_inhibit = pe_req &&  flags_q[pe_blk];
  assign pe_grant   = pe_req && !flags_q[pe_blk];

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(flags_q));
  // R2
  set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ($countones(flags_q ^ $past(flags_q)) <= 1));
  // R3
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (flags_q == '0));
  // R5
  vfy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_valid |-> $past(vfy_req));
  // R6
  pe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_inhibit |-> !pe_grant);
endmodule

// File: rtl/blkprot_ctrl.sv
module blkprot_ctrl
  import blkprot_pkg::*;
#(
  parameter int BLK_BITS   = 4,
  parameter int PROT_CYC   = 10000,
  parameter int UNPROT_CYC = 1000000,
  localparam int NBLK  = 1 << BLK_BITS,
  localparam int CNT_W = $clog2(UNPROT_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sb_prot,
  input  logic                sb_unprot,
  input  logic [BLK_BITS-1:0] sb_blk,
  input  logic                cmd_prot,
  input  logic                cmd_unprot,
  input  logic [BLK_BITS-1:0] cmd_blk,
  input  logic                vfy_req,
  input  logic [BLK_BITS-1:0] vfy_blk,
  input  logic                pe_req,
  input  logic [BLK_BITS-1:0] pe_blk,
  output logic [7:0]          vfy_data,
  output logic                vfy_valid,
  output logic                busy,
  output logic                pe_inhibit,
  output logic                pe_grant,
  output logic                unprot_err
);
  logic                prot_go, unprot_go, unprot_ok, unprot_bad;
  logic [BLK_BITS-1:0] go_blk, blk_q;
  logic                start, expire, running, all_set;
  logic                set_en, clr_en;
  logic [NBLK-1:0]     flags;
  logic [CNT_W-1:0]    load;
  op_e                 op_q;

  blkprot_req_arb #(.BLK_BITS(BLK_BITS)) u_arb (
    .idle(!running), .sb_prot(sb_prot), .sb_unprot(sb_unprot), .sb_blk(sb_blk),
    .cmd_prot(cmd_prot), .cmd_unprot(cmd_unprot), .cmd_blk(cmd_blk),
    .prot_go(prot_go), .unprot_go(unprot_go), .go_blk(go_blk));

  assign all_set    = &flags;
  assign unprot_ok  = unprot_go &&  all_set;
  assign unprot_bad = unprot_go && !all_set;
  assign start      = prot_go || unprot_ok;
  assign load       = prot_go ? CNT_W'(PROT_CYC - 1) : CNT_W'(UNPROT_CYC - 1);

  blkprot_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .running(running), .expire(expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_NONE;
      blk_q      <= '0;
      unprot_err <= 1'b0;
    end else begin
      unprot_err <= unprot_bad;
      if (start) begin
        op_q  <= prot_go ? OP_PROT : OP_UNPROT;
        blk_q <= go_blk;
      end else if (expire) begin
        op_q  <= OP_NONE;
      end
    end
  end

  assign set_en = expire && (op_q == OP_PROT);
  assign clr_en = expire && (op_q == OP_UNPROT);
  assign busy   = running;

  blkprot_flags #(.BLK_BITS(BLK_BITS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_blk(blk_q), .clr_en(clr_en),
    .vfy_req(vfy_req), .vfy_blk(vfy_blk), .pe_req(pe_req), .pe_blk(pe_blk),
    .flags(flags), .vfy_data(vfy_data), .vfy_valid(vfy_valid),
    .pe_inhibit(pe_inhibit), .pe_grant(pe_grant));

  // R4
  err_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unprot_err |-> !(&flags));
  // R4
  err_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unprot_err |-> !busy);
  // R3
  unprot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_UNPROT) |-> (&flags));
  // R10
  go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prot_go && unprot_go));
endmodule

// File: tb/tb_blkprot_ctrl.sv
module tb_blkprot_ctrl;
  localparam int BB = 4;
  localparam int NB = 1 << BB;
  localparam int PC = 12;
  localparam int UC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sb_prot = 0, sb_unprot = 0, cmd_prot = 0, cmd_unprot = 0, vfy_req = 0, pe_req = 0;
  logic [BB-1:0] sb_blk = '0, cmd_blk = '0, vfy_blk = '0, pe_blk = '0;
  logic [7:0] vfy_data;
  logic vfy_valid, busy, pe_inhibit, pe_grant, unprot_err;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  blkprot_ctrl #(.BLK_BITS(BB), .PROT_CYC(PC), .UNPROT_CYC(UC)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic verify(input string req, input int b, input int exp);
    @(negedge clk); vfy_req = 1; vfy_blk = BB'(b);
    @(negedge clk); vfy_req = 0;
    check(req, {vfy_valid, vfy_data}, {1'b1, 8'(exp)});
  endtask

  // protect via sideband (sb=1) or command path; checks the exact busy window
  task automatic protect(input string req, input bit sb, input int b);
    @(negedge clk);
    if (sb) begin sb_prot = 1; sb_blk = BB'(b); end
    else    begin cmd_prot = 1; cmd_blk = BB'(b); end
    @(negedge clk); sb_prot = 0; cmd_prot = 0;
    check(req, busy, 1);
    repeat (PC - 1) @(negedge clk);
    check(req, busy, 1);
    @(negedge clk);
    check(req, busy, 0);
  endtask

  task automatic t_reset();
    check("R1", {busy, unprot_err}, 0);
    verify("R1", 0, 8'h00);
    verify("R1", NB - 1, 8'h00);
  endtask

  task automatic t_protect_sb();
    protect("R2", 1, 3);
    verify("R2", 3, 8'h01);
    verify("R2", 2, 8'h00);
    verify("R2", 4, 8'h00);
  endtask

  task automatic t_pe();
    @(negedge clk); pe_req = 1; pe_blk = 3; #1;
    check("R6", {pe_inhibit, pe_grant}, 2'b10);
    pe_blk = 4; #1;
    check("R7", {pe_inhibit, pe_grant}, 2'b01);
    pe_req = 0;
  endtask

  task automatic t_unprot_early();
    @(negedge clk); cmd_unprot = 1;
    @(negedge clk); cmd_unprot = 0;
    check("R4", {unprot_err, busy}, 2'b10);
    @(negedge clk);
    check("R4", unprot_err, 0);
    verify("R4", 3, 8'h01);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk); sb_prot = 1; sb_blk = 6;
    @(negedge clk); sb_blk = 5; cmd_prot = 1; cmd_blk = 7; sb_unprot = 1;
    @(negedge clk); sb_prot = 0; cmd_prot = 0; sb_unprot = 0;
    check("R8", unprot_err, 0);
    repeat (PC) @(negedge clk);
    check("R8", busy, 0);
    verify("R8", 6, 8'h01);
    verify("R8", 5, 8'h00);
    verify("R8", 7, 8'h00);
  endtask

  task automatic t_cmd_path();
    protect("R9", 0, 9);
    verify("R9", 9, 8'h01);
    @(negedge clk); sb_prot = 1; sb_blk = 10; cmd_prot = 1; cmd_blk = 11;
    @(negedge clk); sb_prot = 0; cmd_prot = 0;
    repeat (PC) @(negedge clk);
    verify("R9", 10, 8'h01);
    verify("R9", 11, 8'h00);
  endtask

  task automatic t_prot_vs_unprot();
    @(negedge clk); sb_unprot = 1; cmd_prot = 1; cmd_blk = 12;
    @(negedge clk); sb_unprot = 0; cmd_prot = 0;
    check("R10", {busy, unprot_err}, 2'b10);
    repeat (PC) @(negedge clk);
    verify("R10", 12, 8'h01);
  endtask

  task automatic t_unprot_all();
    for (int b = 0; b < NB; b++) begin
      @(negedge clk); sb_prot = 1; sb_blk = BB'(b);
      @(negedge clk); sb_prot = 0;
      repeat (PC) @(negedge clk);
    end
    verify("R3", 0, 8'h01);
    @(negedge clk); sb_unprot = 1;
    @(negedge clk); sb_unprot = 0;
    check("R3", {busy, unprot_err}, 2'b10);
    repeat (UC - 1) @(negedge clk);
    check("R3", busy, 1);
    @(negedge clk);
    check("R3", busy, 0);
    for (int b = 0; b < NB; b += 5) verify("R3", b, 8'h00);
    @(negedge clk); pe_req = 1; pe_blk = 3; #1;
    check("R7", {pe_inhibit, pe_grant}, 2'b01);
    pe_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_protect_sb();
    t_pe();
    t_unprot_early();
    t_busy_ignore();
    t_cmd_path();
    t_prot_vs_unprot();
    t_unprot_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule